// File: doc/BRIEF.md
# Charge-Balance Load-Step Transient Controller

This block sits between a linear voltage-loop compensator and the PWM generator of a synchronous buck converter. It works on one signed sample set per switching period, made up of load current, inductor current and capacitor current. While the output is settled it forwards the compensator's duty word unchanged. When the load current jumps by more than a programmable amount from one sample to the next, the block overrides the duty word. It first drives the inductor at its steepest slew toward the new load. Once the inductor reaches a peak or valley target supplied from outside, it reverses the slew. Throughout the override it integrates capacitor current.

A further step that arrives during the override re-arms the steep-slew phase in the direction of the new step. The running charge integral is kept, so a chain of load changes is treated as one transient. Control goes back to the compensator after two conditions hold: a capacitor-current sign change has been seen, and both the integrated charge and the inductor-to-load current error lie inside their tolerances. A sample-count limit forces the hand-back if balance never arrives.

Top module: `cbc_transient_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the block in steady mode. In steady mode `override` is 0, `cap_zc` is 0 and the integral is cleared.
- R2: In steady mode `duty_out` equals `lin_duty` in the same cycle. A step is declared on a valid sample when the load sample minus the previous valid load sample is greater than `+step_thresh` (rising) or less than `-step_thresh` (falling). The first valid sample after reset is never a step.
- R3: From the sample after a step is declared, `override` is 1. `duty_out` is all ones (full scale) for a rising step and all zeros for a falling step.
- R4: In the steep-slew phase, a valid sample with `i_ind >= peak_tgt` (rising) or `i_ind <= valley_tgt` (falling) moves the block to the reverse phase from the next sample. In the reverse phase `duty_out` is all zeros for rising and all ones for falling.
- R5: `cap_zc` is 1 exactly on a valid sample taken during override whose `i_cap` sign differs from the sign of the previous valid sample's `i_cap`. Zero counts as non-negative.
- R6: A step declared during override returns the block to the steep-slew phase in the new direction from the next sample. The charge integral keeps its value, and the record of a seen sign change is cleared.
- R7: The integral is the sum of `i_cap` over the valid samples taken during override. In the reverse phase, a valid sample ends the override when three conditions hold: a sign change has been seen since the last arm, the integral before that sample has magnitude at most `q_tol`, and `|i_ind - i_load| <= i_tol`.
- R8: After override ends, the block spends exactly one valid sample in a hand-back state. There `override` is 0 and `duty_out` equals `lin_duty`, and a step on that sample is not acted on. The block then returns to steady mode.
- R9: The override ends on its MAX_CNT-th valid sample whatever else that sample shows, taking priority over a new step.
- R10: Samples with `smp_vld` low change no state. The outputs keep their mode, and step and sign references are unchanged.
- R11: With SAT_EN set, the integral saturates at the signed ACC_W-bit limits instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | One-cycle strobe marking a new sample set (once per switching period) |
| i_load | input | DATA_W | Signed load-current sample |
| i_ind | input | DATA_W | Signed inductor-current sample |
| i_cap | input | DATA_W | Signed capacitor-current sample |
| lin_duty | input | DUTY_W | Duty word from the linear compensator |
| step_thresh | input | DATA_W | Unsigned step-detection threshold |
| peak_tgt | input | DATA_W | Signed inductor peak target for rising steps |
| valley_tgt | input | DATA_W | Signed inductor valley target for falling steps |
| q_tol | input | ACC_W | Unsigned tolerance on the charge integral magnitude |
| i_tol | input | DATA_W | Unsigned tolerance on inductor-to-load current error |
| duty_out | output | DUTY_W | Duty word to the PWM generator |
| override | output | 1 | High while the transient override drives the duty |
| cap_zc | output | 1 | Capacitor-current sign-change event during override |

## Verification
The bench builds the block with 8-bit samples, a 6-bit duty word, a 12-bit saturating integral and a 48-sample limit. These small widths allow a full sweep of threshold values against signed load deltas around the strict-comparison edge. They also let a run of full-scale capacitor samples drive the integral into saturation and then back to balance within the sample limit. A sample-accurate arithmetic model covers directed chains of opposite and same-direction steps, hand-back hold-off, strobe gaps and a long randomised load walk.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

   typedef enum logic [1:0] {
      ST_STEADY   = 2'd0,
      ST_MAX_SLEW = 2'd1,
      ST_REV_SLEW = 2'd2,
      ST_EXIT     = 2'd3
   } cbc_state_e;

   function automatic logic is_active(input cbc_state_e s);
      return (s == ST_MAX_SLEW) || (s == ST_REV_SLEW);
   endfunction

endpackage

// File: rtl/cbc_step_detect.sv
module cbc_step_detect #(
   parameter int DATA_W = 12
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     smp_vld,
   input  logic signed [DATA_W-1:0] i_load,
   input  logic signed [DATA_W-1:0] i_cap,
   input  logic        [DATA_W-1:0] thresh,
   output logic                     step_up,
   output logic                     step_dn,
   output logic                     cap_flip
);
   localparam int DW1 = DATA_W + 1;

   logic signed [DATA_W-1:0] prev_load;
   logic                     prev_neg;
   logic                     primed;
   logic signed [DW1-1:0]    delta;
   logic signed [DW1-1:0]    th_pos;
   logic signed [DW1-1:0]    th_neg;

   assign delta  = $signed({i_load[DATA_W-1], i_load}) - $signed({prev_load[DATA_W-1], prev_load});
   assign th_pos = $signed({1'b0, thresh});
   assign th_neg = -th_pos;

   assign step_up  = primed & (delta > th_pos);
   assign step_dn  = primed & (delta < th_neg);
   assign cap_flip = primed & (prev_neg ^ i_cap[DATA_W-1]);

   always_ff @(posedge clk) begin
      if (rst) begin
         primed    <= 1'b0;
         prev_load <= '0;
         prev_neg  <= 1'b0;
      end else if (smp_vld) begin
         primed    <= 1'b1;
         prev_load <= i_load;
         prev_neg  <= i_cap[DATA_W-1];
      end
   end
endmodule

// File: rtl/cbc_charge_acc.sv
module cbc_charge_acc #(
   parameter int DATA_W = 12,
   parameter int ACC_W  = 24,
   parameter bit SAT_EN = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     smp_vld,
   input  logic                     clr,
   input  logic signed [DATA_W-1:0] i_cap,
   output logic signed [ACC_W-1:0]  acc
);
   localparam int AW1 = ACC_W + 1;
   localparam logic signed [AW1-1:0] MAXV = $signed({2'b00, {(ACC_W-1){1'b1}}});
   localparam logic signed [AW1-1:0] MINV = $signed({2'b11, {(ACC_W-1){1'b0}}});

   logic signed [AW1-1:0]   sum;
   logic signed [ACC_W-1:0] nxt;

   assign sum = $signed({acc[ACC_W-1], acc})
              + $signed({{(AW1-DATA_W){i_cap[DATA_W-1]}}, i_cap});

   generate
      if (SAT_EN) begin : g_sat
         always_comb begin
            if (sum > MAXV)      nxt = MAXV[ACC_W-1:0];
            else if (sum < MINV) nxt = MINV[ACC_W-1:0];
            else                 nxt = sum[ACC_W-1:0];
         end
      end else begin : g_wrap
         assign nxt = sum[ACC_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)          acc <= '0;
      else if (smp_vld) acc <= clr ? '0 : nxt;
   end
endmodule

// File: rtl/cbc_seq_fsm.sv
module cbc_seq_fsm
   import cbc_pkg::*;
#(
   parameter int DATA_W  = 12,
   parameter int ACC_W   = 24,
   parameter int MAX_CNT = 4096
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     smp_vld,
   input  logic                     step_up,
   input  logic                     step_dn,
   input  logic                     cap_flip,
   input  logic signed [DATA_W-1:0] i_load,
   input  logic signed [DATA_W-1:0] i_ind,
   input  logic signed [DATA_W-1:0] peak_tgt,
   input  logic signed [DATA_W-1:0] valley_tgt,
   input  logic        [ACC_W-1:0]  q_tol,
   input  logic        [DATA_W-1:0] i_tol,
   input  logic signed [ACC_W-1:0]  acc,
   output cbc_state_e               state,
   output logic                     dir_up,
   output logic                     active,
   output logic                     zc_evt
);
   localparam int CNT_W = $clog2(MAX_CNT + 1);
   localparam int AW1   = ACC_W + 1;
   localparam int DW1   = DATA_W + 1;

   logic [CNT_W-1:0]      cnt;
   logic                  zc_seen;
   logic [AW1-1:0]        acc_abs;
   logic signed [AW1-1:0] acc_ext;
   logic signed [DW1-1:0] err;
   logic [DW1-1:0]        err_abs;
   logic                  any_step;
   logic                  wd_hit;
   logic                  peak_hit;
   logic                  bal_ok;

   assign active   = is_active(state);
   assign zc_evt   = smp_vld & active & cap_flip;
   assign any_step = step_up | step_dn;
   assign wd_hit   = (cnt == CNT_W'(MAX_CNT - 1));

   assign acc_ext = $signed({acc[ACC_W-1], acc});
   assign acc_abs = acc_ext[AW1-1] ? AW1'(-acc_ext) : AW1'(acc_ext);
   assign err     = $signed({i_ind[DATA_W-1], i_ind}) - $signed({i_load[DATA_W-1], i_load});
   assign err_abs = err[DW1-1] ? DW1'(-err) : DW1'(err);

   assign peak_hit = dir_up ? (i_ind >= peak_tgt) : (i_ind <= valley_tgt);
   assign bal_ok   = zc_seen
                   && (acc_abs <= {1'b0, q_tol})
                   && (err_abs <= {1'b0, i_tol});

   always_ff @(posedge clk) begin
      if (rst) begin
         state   <= ST_STEADY;
         dir_up  <= 1'b0;
         cnt     <= '0;
         zc_seen <= 1'b0;
      end else if (smp_vld) begin
         unique case (state)
            ST_STEADY: begin
               if (any_step) begin
                  state   <= ST_MAX_SLEW;
                  dir_up  <= step_up;
                  cnt     <= '0;
                  zc_seen <= 1'b0;
               end
            end
            ST_MAX_SLEW, ST_REV_SLEW: begin
               cnt <= cnt + 1'b1;
               if (cap_flip) zc_seen <= 1'b1;
               if (wd_hit) begin
                  state <= ST_EXIT;
               end else if (any_step) begin
                  state   <= ST_MAX_SLEW;
                  dir_up  <= step_up;
                  zc_seen <= 1'b0;
               end else if (state == ST_MAX_SLEW && peak_hit) begin
                  state <= ST_REV_SLEW;
               end else if (state == ST_REV_SLEW && bal_ok) begin
                  state <= ST_EXIT;
               end
            end
            ST_EXIT: state <= ST_STEADY;
            default: state <= ST_STEADY;
         endcase
      end
   end
endmodule

// File: rtl/cbc_transient_ctrl.sv
module cbc_transient_ctrl
   import cbc_pkg::*;
#(
   parameter int DATA_W  = 12,
   parameter int DUTY_W  = 10,
   parameter int ACC_W   = 24,
   parameter int MAX_CNT = 4096,
   parameter bit SAT_EN  = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     smp_vld,
   input  logic signed [DATA_W-1:0] i_load,
   input  logic signed [DATA_W-1:0] i_ind,
   input  logic signed [DATA_W-1:0] i_cap,
   input  logic        [DUTY_W-1:0] lin_duty,
   input  logic        [DATA_W-1:0] step_thresh,
   input  logic signed [DATA_W-1:0] peak_tgt,
   input  logic signed [DATA_W-1:0] valley_tgt,
   input  logic        [ACC_W-1:0]  q_tol,
   input  logic        [DATA_W-1:0] i_tol,
   output logic        [DUTY_W-1:0] duty_out,
   output logic                     override,
   output logic                     cap_zc
);
   localparam logic [DUTY_W-1:0] DUTY_FULL = {DUTY_W{1'b1}};
   localparam logic [DUTY_W-1:0] DUTY_ZERO = '0;

   generate
      if (DATA_W < 4)       begin : g_bad_data  $error("DATA_W must be at least 4");       end
      if (DUTY_W < 2)       begin : g_bad_duty  $error("DUTY_W must be at least 2");       end
      if (ACC_W <= DATA_W)  begin : g_bad_acc   $error("ACC_W must exceed DATA_W");        end
      if (MAX_CNT < 2)      begin : g_bad_cnt   $error("MAX_CNT must be at least 2");      end
   endgenerate

   logic                    step_up;
   logic                    step_dn;
   logic                    cap_flip;
   logic                    dir_up;
   logic                    active;
   logic                    zc_evt;
   logic signed [ACC_W-1:0] acc;
   cbc_state_e              state;

   cbc_step_detect #(.DATA_W(DATA_W)) u_det (
      .clk      (clk),
      .rst      (rst),
      .smp_vld  (smp_vld),
      .i_load   (i_load),
      .i_cap    (i_cap),
      .thresh   (step_thresh),
      .step_up  (step_up),
      .step_dn  (step_dn),
      .cap_flip (cap_flip)
   );

   cbc_charge_acc #(.DATA_W(DATA_W), .ACC_W(ACC_W), .SAT_EN(SAT_EN)) u_acc (
      .clk     (clk),
      .rst     (rst),
      .smp_vld (smp_vld),
      .clr     (!active),
      .i_cap   (i_cap),
      .acc     (acc)
   );

   cbc_seq_fsm #(.DATA_W(DATA_W), .ACC_W(ACC_W), .MAX_CNT(MAX_CNT)) u_fsm (
      .clk        (clk),
      .rst        (rst),
      .smp_vld    (smp_vld),
      .step_up    (step_up),
      .step_dn    (step_dn),
      .cap_flip   (cap_flip),
      .i_load     (i_load),
      .i_ind      (i_ind),
      .peak_tgt   (peak_tgt),
      .valley_tgt (valley_tgt),
      .q_tol      (q_tol),
      .i_tol      (i_tol),
      .acc        (acc),
      .state      (state),
      .dir_up     (dir_up),
      .active     (active),
      .zc_evt     (zc_evt)
   );

   always_comb begin
      unique case (state)
         ST_MAX_SLEW: duty_out = dir_up ? DUTY_FULL : DUTY_ZERO;
         ST_REV_SLEW: duty_out = dir_up ? DUTY_ZERO : DUTY_FULL;
         default:     duty_out = lin_duty;
      endcase
   end

   assign override = active;
   assign cap_zc   = zc_evt;
endmodule

// File: rtl/cbc_transient_ctrl_chk.sv
module cbc_transient_ctrl_chk #(
   parameter int DUTY_W  = 10,
   parameter int MAX_CNT = 4096
) (
   input logic              clk,
   input logic              rst,
   input logic              smp_vld,
   input logic [DUTY_W-1:0] lin_duty,
   input logic [DUTY_W-1:0] duty_out,
   input logic              override,
   input logic              cap_zc
);
   localparam int CW = $clog2(MAX_CNT + 2);

   logic [CW-1:0] ovr_cnt;

   always_ff @(posedge clk) begin
      if (rst || !override) ovr_cnt <= '0;
      else if (smp_vld)     ovr_cnt <= ovr_cnt + 1'b1;
   end

   AST_STEADY_PASS: assert property (@(posedge clk) disable iff (rst)
      !override |-> duty_out == lin_duty);                                   // R2
   AST_DUTY_EXTREME: assert property (@(posedge clk) disable iff (rst)
      override |-> (duty_out == '0 || duty_out == {DUTY_W{1'b1}}));           // R3
   AST_ZC_IN_OVERRIDE: assert property (@(posedge clk) disable iff (rst)
      cap_zc |-> (override && smp_vld));                                      // R5
   AST_HANDBACK_HOLD: assert property (@(posedge clk) disable iff (rst)
      ($fell(override) && smp_vld) |=> !override);                            // R8
   AST_WATCHDOG_BOUND: assert property (@(posedge clk) disable iff (rst)
      (override && smp_vld) |-> ovr_cnt < CW'(MAX_CNT));                      // R9
   AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !smp_vld |=> $stable(override));                                        // R10
endmodule

bind cbc_transient_ctrl cbc_transient_ctrl_chk #(.DUTY_W(DUTY_W), .MAX_CNT(MAX_CNT)) chk_i (
   .clk      (clk),
   .rst      (rst),
   .smp_vld  (smp_vld),
   .lin_duty (lin_duty),
   .duty_out (duty_out),
   .override (override),
   .cap_zc   (cap_zc)
);

// File: tb/cbc_transient_ctrl_tb_top.sv
`timescale 1ns/1ps
module cbc_transient_ctrl_tb_top;
   localparam int DW   = 8;
   localparam int UW   = 6;
   localparam int AW   = 12;
   localparam int MC   = 48;
   localparam int FULL = 63;
   localparam int AMAX = 2047;
   localparam int AMIN = -2048;

   logic                 clk = 1'b0;
   logic                 rst = 1'b1;
   logic                 smp_vld = 1'b0;
   logic signed [DW-1:0] i_load = '0, i_ind = '0, i_cap = '0;
   logic        [UW-1:0] lin_duty = 6'd21;
   logic        [DW-1:0] step_thresh = 8'd3;
   logic signed [DW-1:0] peak_tgt = 8'sd40, valley_tgt = -8'sd40;
   logic        [AW-1:0] q_tol = 12'd2;
   logic        [DW-1:0] i_tol = 8'd2;
   logic        [UW-1:0] duty_out;
   logic                 override, cap_zc;

   int n_chk = 0, n_err = 0;
   bit done = 0;
   // model
   int m_st, m_up, m_acc, m_cnt, m_zcs, m_pL, m_pC, m_pr;
   int th = 3, pk = 40, vl = -40, qt = 2, it = 2;

   always #2 clk = ~clk;

   cbc_transient_ctrl #(.DATA_W(DW), .DUTY_W(UW), .ACC_W(AW), .MAX_CNT(MC), .SAT_EN(1'b1)) dut_i (
      .clk(clk), .rst(rst), .smp_vld(smp_vld), .i_load(i_load), .i_ind(i_ind), .i_cap(i_cap),
      .lin_duty(lin_duty), .step_thresh(step_thresh), .peak_tgt(peak_tgt), .valley_tgt(valley_tgt),
      .q_tol(q_tol), .i_tol(i_tol), .duty_out(duty_out), .override(override), .cap_zc(cap_zc));

   task automatic set_cfg(input int t, input int p, input int v, input int q, input int ti);
      th = t; pk = p; vl = v; qt = q; it = ti;
      step_thresh = 8'(t); peak_tgt = 8'(p); valley_tgt = 8'(v); q_tol = 12'(q); i_tol = 8'(ti);
   endtask

   task automatic chk(input string tag, input int L, input int C, input bit v);
      int e_duty, e_ovr, e_zc, act;
      act    = (m_st == 1 || m_st == 2);
      e_ovr  = act;
      e_duty = (m_st == 1) ? (m_up ? FULL : 0) : (m_st == 2) ? (m_up ? 0 : FULL) : int'(lin_duty);
      e_zc   = (v && m_pr && act && ((m_pC < 0) != (C < 0))) ? 1 : 0;
      n_chk++;
      if (int'(duty_out) != e_duty || int'(override) != e_ovr || int'(cap_zc) != e_zc) begin
         n_err++;
         $display("FAIL %s: duty=%0d ovr=%0d zc=%0d expected duty=%0d ovr=%0d zc=%0d (load=%0d)",
                  tag, duty_out, override, cap_zc, e_duty, e_ovr, e_zc, L);
      end
   endtask

   task automatic mstep(input int L, input int I, input int C);
      int d, su, sd, zc, act, na, ab, ae;
      d   = L - m_pL;
      su  = (m_pr && d > th);
      sd  = (m_pr && d < -th);
      act = (m_st == 1 || m_st == 2);
      zc  = (m_pr && act && ((m_pC < 0) != (C < 0)));
      if (m_st == 0) begin
         m_acc = 0;
         if (su || sd) begin m_st = 1; m_up = su; m_cnt = 0; m_zcs = 0; end
      end else if (act) begin
         ab = (m_acc < 0) ? -m_acc : m_acc;
         ae = (I - L < 0) ? L - I : I - L;
         if (m_cnt == MC - 1) m_st = 3;
         else if (su || sd) begin m_st = 1; m_up = su; end
         else if (m_st == 1 && (m_up ? (I >= pk) : (I <= vl))) m_st = 2;
         else if (m_st == 2 && m_zcs && ab <= qt && ae <= it) m_st = 3;
         na = m_acc + C;
         m_acc = (na > AMAX) ? AMAX : (na < AMIN) ? AMIN : na;
         m_cnt++;
         if (zc) m_zcs = 1;
         if (!(m_cnt == MC) && (su || sd) && m_st == 1 && !(m_cnt - 1 == MC - 1)) m_zcs = 0;
      end else begin
         m_st = 0; m_acc = 0;
      end
      m_pr = 1; m_pL = L; m_pC = C;
   endtask

   task automatic apply(input int L, input int I, input int C, input bit v, input string tag);
      @(negedge clk);
      i_load = 8'(L); i_ind = 8'(I); i_cap = 8'(C); smp_vld = v;
      #1;
      chk(tag, L, C, v);
      if (v) mstep(L, I, C);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; smp_vld = 1'b0;
      repeat (2) @(negedge clk);
      m_st = 0; m_up = 0; m_acc = 0; m_cnt = 0; m_zcs = 0; m_pL = 0; m_pC = 0; m_pr = 0;
      rst = 1'b0;
      #1;
      chk("R1 reset state", 0, 0, 1'b0);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      set_cfg(3, 40, -40, 2, 2);
      do_reset();
      // R2: first sample never a step
      apply(100, 0, 0, 1, "R2 first sample");
      apply(100, 0, 0, 1, "R2 first sample no step");
      // R2: threshold sweep, strict comparison both directions
      for (int t = 0; t <= 4; t++) begin
         for (int d = -6; d <= 6; d++) begin
            do_reset();
            set_cfg(t, 40, -40, 2, 2);
            apply(10, 0, 0, 1, "R2 prime");
            apply(10 + d, 0, 0, 1, "R2 step sample");
            apply(10 + d, 0, 0, 1, "R2 R3 threshold decision");
         end
      end
      // R3 R4 R5 R7 R8: single rising transient to balance and hand-back
      set_cfg(3, 40, -40, 2, 2);
      do_reset();
      apply(0, 0, 0, 1, "R3 prime");
      apply(10, 0, 0, 1, "R3 detect");
      apply(10, 20, -5, 1, "R3 full duty");
      apply(10, 45, -3, 1, "R4 peak reached");
      apply(10, 45, 2, 1, "R4 R5 reverse and crossing");
      apply(10, 10, 6, 1, "R7 not yet balanced");
      apply(10, 10, 0, 1, "R7 balance");
      apply(30, 10, 0, 1, "R8 step ignored in hand-back");
      apply(30, 10, 0, 1, "R8 back in steady");
      apply(30, 10, 0, 1, "R8 steady hold");
      // R6: falling step, then a rising step during override
      do_reset();
      apply(50, 50, 0, 1, "R6 prime");
      apply(30, 50, 0, 1, "R6 falling detect");
      apply(30, 40, 3, 1, "R3 zero duty falling");
      apply(45, 35, -2, 1, "R6 opposite step");
      apply(45, 38, 1, 1, "R6 rearmed rising");
      apply(45, 60, -1, 1, "R4 peak after rearm");
      apply(60, 60, 2, 1, "R6 same-direction rearm");
      apply(60, 60, -2, 1, "R6 slewing again");
      // R10: strobe gaps leave everything unchanged
      apply(-100, 90, 100, 0, "R10 gap with wild inputs");
      apply(120, -90, -100, 0, "R10 gap again");
      apply(60, 20, -1, 1, "R10 resume");
      // R9: never reaching peak triggers the limit
      do_reset();
      apply(0, 0, 0, 1, "R9 prime");
      apply(10, 0, 0, 1, "R9 detect");
      for (int k = 0; k < MC + 3; k++)
         apply(10, 0, (k % 3) - 1, 1, "R9 sample limit");
      // R9: limit has priority over a step on the last sample
      do_reset();
      apply(0, 0, 0, 1, "R9 prime");
      apply(10, 0, 0, 1, "R9 detect");
      for (int k = 0; k < MC - 1; k++) apply(10, 0, 1, 1, "R9 run");
      apply(30, 0, 1, 1, "R9 step on last sample");
      apply(30, 0, 1, 1, "R9 limit wins");
      apply(30, 0, 1, 1, "R8 R9 steady after");
      // R11: saturation then return to balance
      set_cfg(3, 40, -40, 1, 2);
      do_reset();
      apply(0, 0, 0, 1, "R11 prime");
      apply(10, 0, 0, 1, "R11 detect");
      for (int k = 0; k < 20; k++) apply(10, (k == 0) ? 45 : 10, 127, 1, "R11 charge up");
      for (int k = 0; k < 16; k++) apply(10, 10, -128, 1, "R11 discharge");
      apply(10, 10, 0, 1, "R11 R7 balance after saturation");
      apply(10, 10, 0, 1, "R11 hand-back");
      // R5 R6 R7: randomised load walk
      set_cfg(4, 30, -30, 6, 4);
      do_reset();
      begin
         int L, I, C;
         L = 0; I = 0;
         for (int k = 0; k < 3000; k++) begin
            if ($urandom_range(9) == 0) L = int'($urandom_range(120)) - 60;
            else L = L + int'($urandom_range(4)) - 2;
            if (L > 100) L = 100;
            if (L < -100) L = -100;
            I = I + int'($urandom_range(16)) - 8;
            if ($urandom_range(3) == 0) I = L + int'($urandom_range(4)) - 2;
            if (I > 120) I = 120;
            if (I < -120) I = -120;
            C = int'($urandom_range(8)) - 4;
            lin_duty = 6'($urandom_range(63));
            apply(L, I, C, ($urandom_range(7) != 0), "R5 R6 R7 random walk");
         end
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule